// File: doc/BRIEF.md
# Console Memory Bus Decoder

This block sits between a 16-bit CPU core and the rest of the console. It decodes a 24-bit byte address and sends each byte or word access to one of four places. Those places are cartridge ROM, a window of controller-port registers, the video controller port, and a work RAM that the block holds itself. Every other address reads as zero and discards writes.

The cartridge and video ports only ever see 16-bit word transactions at even addresses. A byte read fetches the whole word, and the block returns the half selected by address bit 0. A byte write copies the byte into both halves of the word. The controller-port window is byte wide: it takes the low data byte on writes, and its reads come back zero-extended. The work RAM is byte addressed and big-endian for words, and a word that starts on the last byte wraps to the first byte.

Each accepted request gives a completion strobe on the next cycle, together with a read-data strobe for reads. After reset a sequencer clears the RAM to zero, and requests are refused while the clear runs. The RAM depth is a parameter: the default of 4 KB keeps elaboration small, and the full 64 KB configuration sets `RAM_AW` to 16.

Top module: `cbus_decoder`

## Requirements
- R1: A request with address below 0x400000 drives only the cartridge port. On a read it returns the cartridge word; on a write it forwards the request write flag and the data.
- R2: Addresses from 0xC00000 up to 0xDFFFFF drive only the video port, with the same word behaviour as the cartridge.
- R3: Addresses 0xA10000 to 0xA1001F form the I/O window, and address bit 0 is ignored there. Word offsets 0x02, 0x04 and 0x06 select the data register of port 1, port 2 and the extension port, giving `io_port` = 0, 1, 2 with `io_ctl` = 0. Offsets 0x08, 0x0A and 0x0C select the same three ports with `io_ctl` = 1.
- R4: Any other offset in the I/O window asserts no `io_req` and reads as 0x0000.
- R5: Addresses outside the four regions assert no downstream strobe and read as 0x0000. Writes to them change nothing.
- R6: A byte read from cartridge or video space issues a word read at the address with bit 0 cleared. It returns the upper byte of that word for an even address and the lower byte for an odd address, in `rsp_rdata[7:0]` with bits 15:8 zero.
- R7: A byte write to cartridge or video space issues a word write at the even address. The write data carries `req_wdata[7:0]` in both halves.
- R8: Addresses from 0xE00000 upward reach work RAM through their low `RAM_AW` bits only, so the RAM mirrors every 2^`RAM_AW` bytes.
- R9: A RAM word access is big-endian. The byte at the address maps to bits 15:8, and the byte at address+1 maps to bits 7:0, where address+1 wraps inside the RAM. A RAM byte read returns the byte in bits 7:0.
- R10: A RAM byte write changes only the addressed byte.
- R11: An accepted request (`req_valid` with `ready`) raises `rsp_valid` for exactly the following cycle. `rsp_rvalid` rises in that same cycle only for reads.
- R12: After reset, `ready` stays low while the RAM is cleared, and then stays high. Requests made while `ready` is low produce no strobe and no response. Every RAM byte reads as zero once the clear is done.
- R13: An I/O write forwards `req_wdata[7:0]` on `io_wdata`. An I/O read returns `io_rdata` zero-extended to 16 bits, whether the access is a byte or a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = word access, 0 = byte access |
| req_addr | input | 24 | Byte address |
| req_wdata | input | 16 | Write data (byte writes use bits 7:0) |
| ready | output | 1 | High once the RAM clear has finished |
| rsp_valid | output | 1 | Completion strobe, one cycle after acceptance |
| rsp_rvalid | output | 1 | Read data valid |
| rsp_rdata | output | 16 | Read data |
| cart_req | output | 1 | Cartridge word request |
| cart_we | output | 1 | Cartridge write enable |
| cart_addr | output | 24 | Cartridge word address (bit 0 clear) |
| cart_wdata | output | 16 | Cartridge write word |
| cart_rdata | input | 16 | Cartridge read word, same cycle |
| vid_req | output | 1 | Video port word request |
| vid_we | output | 1 | Video port write enable |
| vid_addr | output | 24 | Video port word address (bit 0 clear) |
| vid_wdata | output | 16 | Video port write word |
| vid_rdata | input | 16 | Video port read word, same cycle |
| io_req | output | 1 | I/O register request |
| io_we | output | 1 | I/O write enable |
| io_port | output | 2 | 0 = port 1, 1 = port 2, 2 = extension |
| io_ctl | output | 1 | 0 = data register, 1 = control register |
| io_wdata | output | 8 | I/O write byte |
| io_rdata | input | 8 | I/O read byte, same cycle |

## Verification
The hardest case to reach from the ports is a RAM word that wraps from the last byte back to the first. That one access touches both byte banks at different rows, and its result can only be seen through a later read of the wrapped byte. The bench aims directed accesses at the top address of the space and at mirror images of the same RAM cell. Its random RAM addresses are drawn from a small pool of low offsets, so that reads keep landing on bytes that earlier byte and word writes have already touched. A shadow byte array then predicts every read.

// File: rtl/cbus_pkg.sv
package cbus_pkg;

  localparam int ADDR_W = 24;
  localparam int DATA_W = 16;
  localparam int BYTE_W = DATA_W / 2;

  localparam logic [ADDR_W-1:0] CART_LIMIT = 24'h400000;
  localparam logic [ADDR_W-1:0] IO_BASE    = 24'hA10000;
  localparam logic [ADDR_W-1:0] IO_LIMIT   = 24'hA10020;
  localparam logic [ADDR_W-1:0] VID_BASE   = 24'hC00000;
  localparam logic [ADDR_W-1:0] RAM_BASE   = 24'hE00000;

  typedef enum logic [2:0] {
    TGT_NONE = 3'd0,
    TGT_CART = 3'd1,
    TGT_IO   = 3'd2,
    TGT_VID  = 3'd3,
    TGT_RAM  = 3'd4
  } tgt_e;

  typedef struct packed {
    logic       hit;
    logic [1:0] port;
    logic       ctl;
  } io_sel_t;

  function automatic tgt_e region_of(logic [ADDR_W-1:0] a);
    if (a < CART_LIMIT)                 return TGT_CART;
    if (a >= IO_BASE && a < IO_LIMIT)   return TGT_IO;
    if (a >= VID_BASE && a < RAM_BASE)  return TGT_VID;
    if (a >= RAM_BASE)                  return TGT_RAM;
    return TGT_NONE;
  endfunction

  // word index inside the I/O window (address bit 0 dropped)
  function automatic io_sel_t io_lookup(logic [3:0] widx);
    io_sel_t s;
    s = '0;
    if (widx >= 4'd1 && widx <= 4'd3) begin
      s.hit  = 1'b1;
      s.port = 2'(widx - 4'd1);
      s.ctl  = 1'b0;
    end else if (widx >= 4'd4 && widx <= 4'd6) begin
      s.hit  = 1'b1;
      s.port = 2'(widx - 4'd4);
      s.ctl  = 1'b1;
    end
    return s;
  endfunction

  function automatic logic [BYTE_W-1:0] lane_pick(logic [DATA_W-1:0] w, logic odd);
    return odd ? w[BYTE_W-1:0] : w[DATA_W-1:BYTE_W];
  endfunction

  function automatic logic [DATA_W-1:0] lane_dup(logic [BYTE_W-1:0] b);
    return {b, b};
  endfunction

endpackage

// File: rtl/cbus_addr_decode.sv
module cbus_addr_decode
  import cbus_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output tgt_e              tgt,
  output io_sel_t           io_sel
);

  always_comb begin
    tgt    = region_of(addr);
    io_sel = (tgt == TGT_IO) ? io_lookup(addr[4:1]) : '0;
  end

  always_comb begin
    if (io_sel.hit) begin
      a_io_in_window_r3: assert (tgt == TGT_IO);
    end
  end

endmodule

// File: rtl/cbus_lane_steer.sv
module cbus_lane_steer
  import cbus_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              word,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] cap,
  input  logic              odd_q,
  input  logic              word_q,
  output logic [ADDR_W-1:0] word_addr,
  output logic [DATA_W-1:0] word_wdata,
  output logic [DATA_W-1:0] rd_out
);

  always_comb begin
    word_addr  = {addr[ADDR_W-1:1], 1'b0};
    word_wdata = word ? wdata : lane_dup(wdata[BYTE_W-1:0]);
    rd_out     = word_q ? cap : {{BYTE_W{1'b0}}, lane_pick(cap, odd_q)};
  end

endmodule

// File: rtl/cbus_work_ram.sv
module cbus_work_ram
  import cbus_pkg::*;
#(
  parameter int RAM_AW = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic              word,
  input  logic [RAM_AW-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              ready,
  output logic [DATA_W-1:0] rdata
);

  localparam int ROW_AW = RAM_AW - 1;
  localparam int ROWS   = 1 << ROW_AW;

  logic              clearing;
  logic [ROW_AW-1:0] clr_row;
  logic [RAM_AW-1:0] addr_nx;
  logic              a0_q, word_q;

  assign addr_nx = addr + RAM_AW'(1);
  assign ready   = ~clearing;

  // clear sequencer: one row of both banks per cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clearing <= 1'b1;
      clr_row  <= '0;
    end else if (clearing) begin
      clr_row <= clr_row + ROW_AW'(1);
      if (clr_row == {ROW_AW{1'b1}}) clearing <= 1'b0;
    end
  end

  // even bytes live in bank 0, odd bytes in bank 1
  generate
    for (genvar b = 0; b < 2; b++) begin : g_bank
      logic [BYTE_W-1:0] mem [ROWS];
      logic [BYTE_W-1:0] q;
      logic              first;
      logic [ROW_AW-1:0] row;
      logic              we;
      logic [BYTE_W-1:0] wd;

      always_comb begin
        first = (addr[0] == 1'(b));
        row   = first ? addr[RAM_AW-1:1] : addr_nx[RAM_AW-1:1];
        we    = wr_en & (first | word);
        wd    = (first & word) ? wdata[DATA_W-1:BYTE_W] : wdata[BYTE_W-1:0];
      end

      always_ff @(posedge clk) begin
        if (clearing)  mem[clr_row] <= '0;
        else if (we)   mem[row]     <= wd;
        if (rd_en)     q            <= mem[row];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a0_q   <= 1'b0;
      word_q <= 1'b0;
    end else if (rd_en) begin
      a0_q   <= addr[0];
      word_q <= word;
    end
  end

  logic [BYTE_W-1:0] hi_b, lo_b;
  assign hi_b  = a0_q ? g_bank[1].q : g_bank[0].q;
  assign lo_b  = a0_q ? g_bank[0].q : g_bank[1].q;
  assign rdata = word_q ? {hi_b, lo_b} : {{BYTE_W{1'b0}}, hi_b};

  p_ready_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);

  p_no_access_while_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> !(wr_en || rd_en));

endmodule

// File: rtl/cbus_decoder.sv
module cbus_decoder
  import cbus_pkg::*;
#(
  parameter int RAM_AW = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_word,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              ready,
  output logic              rsp_valid,
  output logic              rsp_rvalid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              cart_req,
  output logic              cart_we,
  output logic [ADDR_W-1:0] cart_addr,
  output logic [DATA_W-1:0] cart_wdata,
  input  logic [DATA_W-1:0] cart_rdata,
  output logic              vid_req,
  output logic              vid_we,
  output logic [ADDR_W-1:0] vid_addr,
  output logic [DATA_W-1:0] vid_wdata,
  input  logic [DATA_W-1:0] vid_rdata,
  output logic              io_req,
  output logic              io_we,
  output logic [1:0]        io_port,
  output logic              io_ctl,
  output logic [BYTE_W-1:0] io_wdata,
  input  logic [BYTE_W-1:0] io_rdata
);

  tgt_e              tgt, tgt_q;
  io_sel_t           io_sel;
  logic              accept;
  logic              ram_rd, ram_wr;
  logic [ADDR_W-1:0] word_addr;
  logic [DATA_W-1:0] word_wdata, steer_rd, ram_rdata, cap_d, cap_q;
  logic              odd_q, word_q;

  cbus_addr_decode u_decode (
    .addr   (req_addr),
    .tgt    (tgt),
    .io_sel (io_sel)
  );

  cbus_lane_steer u_steer (
    .addr       (req_addr),
    .word       (req_word),
    .wdata      (req_wdata),
    .cap        (cap_q),
    .odd_q      (odd_q),
    .word_q     (word_q),
    .word_addr  (word_addr),
    .word_wdata (word_wdata),
    .rd_out     (steer_rd)
  );

  cbus_work_ram #(.RAM_AW(RAM_AW)) u_ram (
    .clk   (clk),
    .rst_n (rst_n),
    .rd_en (ram_rd),
    .wr_en (ram_wr),
    .word  (req_word),
    .addr  (req_addr[RAM_AW-1:0]),
    .wdata (req_wdata),
    .ready (ready),
    .rdata (ram_rdata)
  );

  assign accept = req_valid & ready;

  always_comb begin
    cart_req   = accept & (tgt == TGT_CART);
    cart_we    = req_write;
    cart_addr  = word_addr;
    cart_wdata = word_wdata;
    vid_req    = accept & (tgt == TGT_VID);
    vid_we     = req_write;
    vid_addr   = word_addr;
    vid_wdata  = word_wdata;
    io_req     = accept & io_sel.hit;
    io_we      = req_write;
    io_port    = io_sel.port;
    io_ctl     = io_sel.ctl;
    io_wdata   = req_wdata[BYTE_W-1:0];
    ram_rd     = accept & (tgt == TGT_RAM) & ~req_write;
    ram_wr     = accept & (tgt == TGT_RAM) & req_write;
    unique case (tgt)
      TGT_CART: cap_d = cart_rdata;
      TGT_VID:  cap_d = vid_rdata;
      TGT_IO:   cap_d = io_sel.hit ? {{BYTE_W{1'b0}}, io_rdata} : '0;
      default:  cap_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_rvalid <= 1'b0;
      tgt_q      <= TGT_NONE;
      odd_q      <= 1'b0;
      word_q     <= 1'b0;
      cap_q      <= '0;
    end else begin
      rsp_valid  <= accept;
      rsp_rvalid <= accept & ~req_write;
      if (accept & ~req_write) begin
        tgt_q  <= tgt;
        odd_q  <= req_addr[0];
        word_q <= req_word;
        cap_q  <= cap_d;
      end
    end
  end

  always_comb begin
    unique case (tgt_q)
      TGT_RAM:          rsp_rdata = ram_rdata;
      TGT_CART, TGT_VID: rsp_rdata = steer_rd;
      TGT_IO:           rsp_rdata = cap_q;
      default:          rsp_rdata = '0;
    endcase
  end

  p_single_target_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cart_req, vid_req, io_req, ram_rd | ram_wr}));

  p_resp_next_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ready) |=> (rsp_valid && (rsp_rvalid == !$past(req_write))));

  p_resp_has_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && ready));

  p_unmapped_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && region_of(req_addr) == TGT_NONE) |-> !(cart_req || vid_req || io_req));

  p_byte_dup_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cart_req && cart_we && !req_word) |-> (cart_wdata[15:8] == cart_wdata[7:0]));

  p_even_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cart_req || vid_req) |-> (!cart_addr[0] && !vid_addr[0]));

endmodule

// File: tb/cbus_decoder_tb.sv
module cbus_decoder_tb;

  localparam int CLK_PERIOD = 10;
  localparam int RAM_AW     = 12;
  localparam int RAM_BYTES  = 1 << RAM_AW;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, req_word;
  logic [23:0] req_addr;
  logic [15:0] req_wdata;
  logic        ready, rsp_valid, rsp_rvalid;
  logic [15:0] rsp_rdata;
  logic        cart_req, cart_we, vid_req, vid_we, io_req, io_we, io_ctl;
  logic [23:0] cart_addr, vid_addr;
  logic [15:0] cart_wdata, cart_rdata, vid_wdata, vid_rdata;
  logic [1:0]  io_port;
  logic [7:0]  io_wdata, io_rdata;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;
  logic [7:0] shadow [RAM_BYTES];

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] cart_model(logic [23:0] x);
    return x[15:0] ^ 16'h5A3C ^ {x[23:16], 8'h00};
  endfunction
  function automatic logic [15:0] vid_model(logic [23:0] x);
    return {x[7:0], x[15:8]} ^ 16'h0FF0;
  endfunction
  function automatic logic [7:0] io_model(logic [1:0] p, logic c);
    return {c, 1'b0, p, 4'h9};
  endfunction

  assign cart_rdata = cart_model(cart_addr);
  assign vid_rdata  = vid_model(vid_addr);
  assign io_rdata   = io_model(io_port, io_ctl);

  cbus_decoder #(.RAM_AW(RAM_AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_word(req_word), .req_addr(req_addr), .req_wdata(req_wdata),
    .ready(ready), .rsp_valid(rsp_valid), .rsp_rvalid(rsp_rvalid), .rsp_rdata(rsp_rdata),
    .cart_req(cart_req), .cart_we(cart_we), .cart_addr(cart_addr),
    .cart_wdata(cart_wdata), .cart_rdata(cart_rdata),
    .vid_req(vid_req), .vid_we(vid_we), .vid_addr(vid_addr),
    .vid_wdata(vid_wdata), .vid_rdata(vid_rdata),
    .io_req(io_req), .io_we(io_we), .io_port(io_port), .io_ctl(io_ctl),
    .io_wdata(io_wdata), .io_rdata(io_rdata)
  );

  // 0 none, 1 cart, 2 io, 3 video, 4 ram
  function automatic int reg_of(logic [23:0] a);
    if (a <= 24'h3FFFFF) return 1;
    if (a >= 24'hA10000 && a <= 24'hA1001F) return 2;
    if (a >= 24'hC00000 && a <= 24'hDFFFFF) return 3;
    if (a >= 24'hE00000) return 4;
    return 0;
  endfunction

  // {hit, port[1:0], ctl}
  function automatic logic [3:0] io_map(logic [23:0] a);
    case ({a[4:2], 1'b0} | {3'b000, a[1]})
      4'd1: return 4'b1_00_0;
      4'd2: return 4'b1_01_0;
      4'd3: return 4'b1_10_0;
      4'd4: return 4'b1_00_1;
      4'd5: return 4'b1_01_1;
      4'd6: return 4'b1_10_1;
      default: return 4'b0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic acc(input logic w, input logic wd, input logic [23:0] a,
                     input logic [15:0] d, input string tag);
    int r;
    logic [3:0]  m;
    logic [15:0] w16, exp;
    logic [RAM_AW-1:0] i, i1;
    logic [23:0] ea;
    r  = reg_of(a);
    m  = io_map(a);
    ea = {a[23:1], 1'b0};
    i  = a[RAM_AW-1:0];
    i1 = i + 1'b1;
    exp = 16'h0000;
    case (r)
      1: begin w16 = cart_model(ea); exp = wd ? w16 : {8'h00, a[0] ? w16[7:0] : w16[15:8]}; end
      3: begin w16 = vid_model(ea);  exp = wd ? w16 : {8'h00, a[0] ? w16[7:0] : w16[15:8]}; end
      2: exp = m[3] ? {8'h00, io_model(m[2:1], m[0])} : 16'h0000;
      4: exp = wd ? {shadow[i], shadow[i1]} : {8'h00, shadow[i]};
      default: exp = 16'h0000;
    endcase
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_word = wd; req_addr = a; req_wdata = d;
    #1;
    chk(cart_req == (r == 1), {tag, " cart_req R1"}, 32'(cart_req), 32'(r == 1));
    chk(vid_req == (r == 3), {tag, " vid_req R2"}, 32'(vid_req), 32'(r == 3));
    chk(io_req == ((r == 2) && m[3]), {tag, " io_req R3 R4"}, 32'(io_req), 32'((r == 2) && m[3]));
    if (r == 1) begin
      chk(cart_addr == ea && cart_we == w, {tag, " cart addr/we R6"}, {7'b0, cart_we, cart_addr}, {7'b0, w, ea});
      if (w) chk(cart_wdata == (wd ? d : {d[7:0], d[7:0]}), {tag, " cart wdata R7"},
                 32'(cart_wdata), 32'(wd ? d : {d[7:0], d[7:0]}));
    end
    if (r == 3) begin
      chk(vid_addr == ea && vid_we == w, {tag, " vid addr/we R6"}, {7'b0, vid_we, vid_addr}, {7'b0, w, ea});
      if (w) chk(vid_wdata == (wd ? d : {d[7:0], d[7:0]}), {tag, " vid wdata R7"},
                 32'(vid_wdata), 32'(wd ? d : {d[7:0], d[7:0]}));
    end
    if (r == 2 && m[3]) begin
      chk({io_port, io_ctl, io_we} == {m[2:1], m[0], w}, {tag, " io select R3"},
          32'({io_port, io_ctl, io_we}), 32'({m[2:1], m[0], w}));
      if (w) chk(io_wdata == d[7:0], {tag, " io wdata R13"}, 32'(io_wdata), 32'(d[7:0]));
    end
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid == 1'b1 && rsp_rvalid == !w, {tag, " rsp strobes R11"},
        32'({rsp_valid, rsp_rvalid}), 32'({1'b1, !w}));
    if (!w) chk(rsp_rdata == exp, {tag, " read data"}, 32'(rsp_rdata), 32'(exp));
    if (r == 4 && w) begin
      if (wd) begin shadow[i] = d[15:8]; shadow[i1] = d[7:0]; end
      else shadow[i] = d[7:0];
    end
    @(negedge clk);
    chk(rsp_valid == 1'b0, {tag, " single strobe R11"}, 32'(rsp_valid), 32'(0));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    int cyc;
    int unsigned seed;
    for (int k = 0; k < RAM_BYTES; k++) shadow[k] = 8'h00;
    seed = $urandom(32'd20240611);
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_word = 1'b0;
    req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    chk(rsp_valid == 0 && rsp_rvalid == 0 && ready == 0, "reset state R12",
        32'({rsp_valid, rsp_rvalid, ready}), 32'(0));
    rst_n = 1'b1;

    // R12: request during clear is refused
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_word = 1'b1; req_addr = 24'h000010; req_wdata = 16'h1111;
    #1;
    chk(cart_req == 0 && ready == 0, "request during clear R12", 32'({cart_req, ready}), 32'(0));
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid == 0, "no response during clear R12", 32'(rsp_valid), 32'(0));

    cyc = 2;
    while (!ready && cyc < 10000) begin @(negedge clk); cyc++; end
    chk(ready == 1 && cyc >= RAM_BYTES / 2, "clear length R12", 32'(cyc), 32'(RAM_BYTES / 2));

    acc(0, 1, 24'hE00000, 16'h0, "ram zero R12");
    acc(0, 1, 24'hFFFFFE, 16'h0, "ram zero top R12");
    acc(0, 0, 24'hE00777, 16'h0, "ram zero byte R12");

    // cartridge
    acc(0, 1, 24'h000100, 16'h0, "cart word R1");
    acc(0, 0, 24'h123456, 16'h0, "cart byte even R6");
    acc(0, 0, 24'h123457, 16'h0, "cart byte odd R6");
    acc(1, 1, 24'h000200, 16'hCAFE, "cart word write R1");
    acc(1, 0, 24'h000201, 16'h99AB, "cart byte write R7");
    acc(0, 0, 24'h3FFFFF, 16'h0, "cart top R1");
    acc(0, 1, 24'h400000, 16'h0, "just past cart R5");

    // video
    acc(0, 1, 24'hC00004, 16'h0, "vid word R2");
    acc(0, 0, 24'hDFFFFF, 16'h0, "vid top byte R6");
    acc(1, 0, 24'hC00011, 16'h00AB, "vid byte write R7");
    acc(0, 1, 24'hBFFFFE, 16'h0, "below vid R5");

    // I/O window, every offset both parities
    for (int k = 0; k < 32; k++) acc(0, k[0], 24'hA10000 + 24'(k), 16'h0, "io scan R3 R4 R13");
    acc(1, 0, 24'hA10003, 16'h1234, "io byte write R13");
    acc(1, 1, 24'hA1000A, 16'h5678, "io word write R13");
    acc(0, 1, 24'hA10020, 16'h0, "past io R5");
    acc(0, 1, 24'hA0FFFE, 16'h0, "before io R5");

    // unmapped writes
    acc(1, 1, 24'h500000, 16'hFFFF, "unmapped write R5");
    acc(0, 1, 24'h900000, 16'h0, "unmapped read R5");

    // RAM
    acc(1, 1, 24'hE00010, 16'hBEEF, "ram write R9");
    acc(0, 1, 24'hFF0010, 16'h0, "ram mirror R8");
    acc(0, 1, 24'hE01010, 16'h0, "ram mirror low bits R8");
    acc(1, 1, 24'hFFFFFF, 16'h1234, "ram wrap write R9");
    acc(0, 0, 24'hE00000, 16'h0, "ram wrap low byte R9");
    acc(0, 0, 24'hE00FFF, 16'h0, "ram wrap high byte R9");
    acc(0, 1, 24'hFFFFFF, 16'h0, "ram wrap word R9");
    acc(1, 1, 24'hE00030, 16'hA1B2, "ram setup R10");
    acc(1, 0, 24'hE00031, 16'h0077, "ram byte write R10");
    acc(0, 1, 24'hE00030, 16'h0, "ram neighbor kept R10");
    acc(0, 1, 24'hE00021, 16'h0, "ram odd word R9");

    // constrained random mix
    for (int n = 0; n < 800; n++) begin
      logic [23:0] a;
      int pick;
      pick = int'($urandom % 6);
      case (pick)
        0: a = 24'($urandom % 32'h400000);
        1: a = 24'hA10000 | 24'($urandom % 32);
        2: a = 24'hC00000 | 24'($urandom % 32'h200000);
        3, 4: a = 24'hE00000 | (24'($urandom) & 24'h1FF000) | 24'($urandom % 40) | ((($urandom % 8) == 0) ? 24'h000FD8 : 24'h0);
        default: a = ((($urandom % 2) == 0) ? 24'h400000 : 24'hA10020) + 24'($urandom % 32'h100000);
      endcase
      acc(1'($urandom % 2), 1'($urandom % 2), a, 16'($urandom), "random R1 R2 R9");
    end

    finish_run();
  end

endmodule